// File: doc/BRIEF.md
# System-Management Interrupt Gate

This block sits beside a processor core and decides when the core may take its maskable interrupt (INTR) and its non-maskable interrupt (NMI). It follows the core into and out of system management mode. An entry pulse masks both interrupt classes. A resume pulse leaves the mode, puts back the interrupt flag the core had before entry, and turns NMI delivery back on. While the core is in the mode, handler software may set the interrupt flag and the NMI-enable bit through plain write strobes.

NMI requests are taken on the rising edge of `nmi_in`. If an edge arrives while NMI is masked, the block keeps one pending event; any later edges are folded into it. That event goes to the core as a single-cycle `nmi_req` pulse. The pulse comes one cycle after NMI is unmasked, either by a software write or by resume, whichever happens first. INTR is a level: `intr_req` follows `intr_in` whenever the interrupt flag is set. Every pin is a plain control or status signal. No data stream passes through the block, so it has no handshake and no back-pressure.

Top module: `smm_irq_gate`

## Requirements
- R1: A synchronous active-high `rst` gives `in_smm`=0, `if_flag`=0, `nmi_enable`=1, `nmi_pending`=0 and `nmi_req`=0 on the cycle after reset.
- R2: `smm_enter` sampled high while `in_smm`=0 gives, on the next cycle, `in_smm`=1, `if_flag`=0 and `nmi_enable`=0. While `in_smm`=1, `smm_enter` has no effect.
- R3: `smm_resume` sampled high while `in_smm`=1 gives, on the next cycle, `in_smm`=0, `nmi_enable`=1, and `if_flag` equal to its value on the cycle `smm_enter` was accepted. While `in_smm`=0, `smm_resume` has no effect.
- R4: `if_we`=1 loads `if_wdata` into `if_flag` on the next cycle, except on a cycle where entry or resume is accepted. `intr_req` equals `intr_in & if_flag` in the same cycle.
- R5: `nmien_we`=1 loads `nmien_wdata` into `nmi_enable` on the next cycle only while `in_smm`=1 and no resume is accepted in that cycle. Outside the mode the write is ignored and `nmi_enable` stays 1.
- R6: A rising edge on `nmi_in` (0 on the previous cycle, 1 now) is delivered when NMI is enabled in the following cycle. Delivery is `nmi_req`=1 for exactly one cycle, the cycle after the edge. A held-high `nmi_in` gives no further pulse.
- R7: A rising edge while NMI is disabled in the following cycle sets `nmi_pending` on the next cycle. Any number of further edges before delivery still yield exactly one `nmi_req` pulse.
- R8: A pending NMI, or an edge in the same cycle, is delivered on the cycle after NMI becomes enabled, whether by an enable write or by resume. `nmi_pending` reads 0 in the cycle the pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smm_enter | input | 1 | One-cycle pulse: the core enters system management mode |
| smm_resume | input | 1 | One-cycle pulse: the resume operation leaves the mode |
| if_we | input | 1 | Write strobe for the interrupt flag |
| if_wdata | input | 1 | New interrupt-flag value |
| nmien_we | input | 1 | Write strobe for the NMI-enable control bit |
| nmien_wdata | input | 1 | New NMI-enable value |
| nmi_in | input | 1 | Raw NMI line, rising-edge sensitive |
| intr_in | input | 1 | Maskable interrupt request level |
| in_smm | output | 1 | The core is in system management mode |
| if_flag | output | 1 | Current interrupt flag |
| nmi_enable | output | 1 | Current NMI enable |
| nmi_pending | output | 1 | One masked NMI is being held |
| nmi_req | output | 1 | One-cycle NMI service request to the core |
| intr_req | output | 1 | Gated maskable interrupt request |

## Verification
A corrupted saved flag stays hidden through the whole handler. It shows only on the cycle after resume, when `if_flag` comes back wrong and `intr_req` then follows it. A pending latch that fails to set or clear shows on `nmi_pending` one cycle after the edge. Its effect on `nmi_req` appears only when NMI is next unmasked, which can be many cycles later. For this reason the stimulus keeps resuming and re-enabling at random points, and compares every output every cycle against an independent model.

// File: rtl/smm_gate_pkg.sv
package smm_gate_pkg;

  // reset value of the maskable interrupt flag
  localparam logic IF_RESET_VAL = 1'b0;
  // NMI enable held while outside the management mode
  localparam logic NMI_EN_OUTSIDE = 1'b1;

  typedef struct packed {
    logic in_smm;
    logic if_flag;
    logic nmi_en;
  } smm_ctl_t;

  localparam smm_ctl_t CTL_RESET = '{in_smm: 1'b0, if_flag: IF_RESET_VAL, nmi_en: NMI_EN_OUTSIDE};

endpackage

// File: rtl/smm_mode_ctl.sv
module smm_mode_ctl
  import smm_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     smm_enter,
  input  logic     smm_resume,
  input  logic     if_we,
  input  logic     if_wdata,
  input  logic     nmien_we,
  input  logic     nmien_wdata,
  output smm_ctl_t ctl,
  output logic     nmi_en_next
);

  smm_ctl_t ctl_q, ctl_d;
  logic     if_saved_q, if_saved_d;
  logic     take_enter, take_resume;

  assign take_enter  = smm_enter & ~ctl_q.in_smm;
  assign take_resume = smm_resume & ctl_q.in_smm;

  always_comb begin
    ctl_d      = ctl_q;
    if_saved_d = if_saved_q;
    if (take_enter) begin
      ctl_d.in_smm  = 1'b1;
      ctl_d.if_flag = IF_RESET_VAL;
      ctl_d.nmi_en  = 1'b0;
      if_saved_d    = ctl_q.if_flag;
    end else if (take_resume) begin
      ctl_d.in_smm  = 1'b0;
      ctl_d.if_flag = if_saved_q;
      ctl_d.nmi_en  = NMI_EN_OUTSIDE;
    end else begin
      if (if_we) ctl_d.if_flag = if_wdata;
      if (nmien_we && ctl_q.in_smm) ctl_d.nmi_en = nmien_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= CTL_RESET;
      if_saved_q <= IF_RESET_VAL;
    end else begin
      ctl_q      <= ctl_d;
      if_saved_q <= if_saved_d;
    end
  end

  assign ctl         = ctl_q;
  assign nmi_en_next = ctl_d.nmi_en;

  // R2: an accepted entry masks both classes
  p_enter_masks_r2: assert property (@(posedge clk) disable iff (rst)
    (smm_enter && !ctl_q.in_smm) |=> (ctl_q.in_smm && !ctl_q.if_flag && !ctl_q.nmi_en));

  // R3: an accepted resume leaves the mode with NMI enabled
  p_resume_unmasks_r3: assert property (@(posedge clk) disable iff (rst)
    (smm_resume && ctl_q.in_smm) |=> (!ctl_q.in_smm && ctl_q.nmi_en));

  // R5: outside the mode NMI stays enabled
  p_outside_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.in_smm |-> ctl_q.nmi_en);

endmodule

// File: rtl/nmi_hold.sv
module nmi_hold (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic nmi_en_now,
  input  logic nmi_en_next,
  output logic nmi_req,
  output logic nmi_pending
);

  logic nmi_prev_q, pend_q, req_q;
  logic rise, want, deliver;

  assign rise    = nmi_in & ~nmi_prev_q;
  assign want    = pend_q | rise;
  assign deliver = want & nmi_en_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev_q <= 1'b0;
      pend_q     <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_in;
      pend_q     <= want & ~deliver;
      req_q      <= deliver;
    end
  end

  assign nmi_req     = req_q;
  assign nmi_pending = pend_q;

  // R8: the held event is gone in the cycle its pulse is issued
  p_pulse_clears_r8: assert property (@(posedge clk) disable iff (rst)
    req_q |-> !pend_q);

  // R6: no NMI request while NMI is masked
  p_req_only_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> nmi_en_now);

  // R7: an event is only held while NMI is masked
  p_pend_masked_r7: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !nmi_en_now);

endmodule

// File: rtl/intr_mask.sv
module intr_mask (
  input  logic intr_in,
  input  logic if_flag,
  output logic intr_req
);

  assign intr_req = intr_in & if_flag;

endmodule

// File: rtl/smm_irq_gate.sv
module smm_irq_gate
  import smm_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic smm_enter,
  input  logic smm_resume,
  input  logic if_we,
  input  logic if_wdata,
  input  logic nmien_we,
  input  logic nmien_wdata,
  input  logic nmi_in,
  input  logic intr_in,
  output logic in_smm,
  output logic if_flag,
  output logic nmi_enable,
  output logic nmi_pending,
  output logic nmi_req,
  output logic intr_req
);

  smm_ctl_t ctl;
  logic     en_next;

  smm_mode_ctl u_mode (
    .clk(clk), .rst(rst),
    .smm_enter(smm_enter), .smm_resume(smm_resume),
    .if_we(if_we), .if_wdata(if_wdata),
    .nmien_we(nmien_we), .nmien_wdata(nmien_wdata),
    .ctl(ctl), .nmi_en_next(en_next)
  );

  nmi_hold u_nmi (
    .clk(clk), .rst(rst), .nmi_in(nmi_in),
    .nmi_en_now(ctl.nmi_en), .nmi_en_next(en_next),
    .nmi_req(nmi_req), .nmi_pending(nmi_pending)
  );

  intr_mask u_intr (
    .intr_in(intr_in), .if_flag(ctl.if_flag), .intr_req(intr_req)
  );

  assign in_smm     = ctl.in_smm;
  assign if_flag    = ctl.if_flag;
  assign nmi_enable = ctl.nmi_en;

  // R4: the interrupt flag only changes by write, entry or resume
  p_if_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!if_we && !smm_enter && !smm_resume) |=> $stable(if_flag));

endmodule

// File: tb/test_smm_irq_gate.sv
module test_smm_irq_gate;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smm_enter = 0, smm_resume = 0, if_we = 0, if_wdata = 0;
  logic nmien_we = 0, nmien_wdata = 0, nmi_in = 0, intr_in = 0;
  logic in_smm, if_flag, nmi_enable, nmi_pending, nmi_req, intr_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // reference model state
  logic m_smm, m_if, m_saved, m_en, m_pend, m_req, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_irq_gate i_smm_irq_gate (
    .clk(clk), .rst(rst),
    .smm_enter(smm_enter), .smm_resume(smm_resume),
    .if_we(if_we), .if_wdata(if_wdata),
    .nmien_we(nmien_we), .nmien_wdata(nmien_wdata),
    .nmi_in(nmi_in), .intr_in(intr_in),
    .in_smm(in_smm), .if_flag(if_flag), .nmi_enable(nmi_enable),
    .nmi_pending(nmi_pending), .nmi_req(nmi_req), .intr_req(intr_req)
  );

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_smm = 0; m_if = 0; m_saved = 0; m_en = 1; m_pend = 0; m_req = 0; m_prev = 0;
  endtask

  // next state from the current inputs, per the requirements
  task automatic model_step();
    logic rise, want, n_en;
    rise = nmi_in & ~m_prev;
    if (smm_enter && !m_smm) begin
      m_saved = m_if; m_if = 0; m_en = 0; m_smm = 1;
    end else if (smm_resume && m_smm) begin
      m_if = m_saved; m_en = 1; m_smm = 0;
    end else begin
      if (if_we) m_if = if_wdata;
      if (nmien_we && m_smm) m_en = nmien_wdata;
    end
    n_en   = m_en;
    want   = m_pend | rise;
    m_req  = want & n_en;
    m_pend = want & ~n_en;
    m_prev = nmi_in;
  endtask

  task automatic compare_all();
    check_bit("R2", "in_smm", in_smm, m_smm);
    check_bit("R4", "if_flag", if_flag, m_if);
    check_bit("R5", "nmi_enable", nmi_enable, m_en);
    check_bit("R7", "nmi_pending", nmi_pending, m_pend);
    check_bit("R6", "nmi_req", nmi_req, m_req);
    check_bit("R4", "intr_req", intr_req, intr_in & m_if);
  endtask

  // inputs are set at a negedge; one clock; compare at the next negedge
  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    smm_enter = 0; smm_resume = 0; if_we = 0; nmien_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check_bit("R1", "in_smm", in_smm, 1'b0);
    check_bit("R1", "if_flag", if_flag, 1'b0);
    check_bit("R1", "nmi_enable", nmi_enable, 1'b1);
    check_bit("R1", "nmi_pending", nmi_pending, 1'b0);
    check_bit("R1", "nmi_req", nmi_req, 1'b0);

    // R4: set IF outside, intr passes
    if_we = 1; if_wdata = 1; intr_in = 1; cycle(); idle();
    check_bit("R4", "intr_req pass", intr_req, 1'b1);
    // R5: enable write outside is ignored
    nmien_we = 1; nmien_wdata = 0; cycle(); idle();
    check_bit("R5", "outside write ignored", nmi_enable, 1'b1);
    // R2: enter
    smm_enter = 1; cycle(); idle();
    check_bit("R2", "intr masked", intr_req, 1'b0);
    // R7: three edges while masked
    for (int k = 0; k < 3; k++) begin
      nmi_in = 1; cycle(); nmi_in = 0; cycle();
    end
    check_bit("R7", "one held", nmi_pending, 1'b1);
    // R2: second entry ignored
    smm_enter = 1; if_we = 0; cycle(); idle();
    // R3: resume releases held NMI and restores IF
    smm_resume = 1; cycle(); idle();
    check_bit("R8", "pulse on resume", nmi_req, 1'b1);
    check_bit("R8", "cleared with pulse", nmi_pending, 1'b0);
    check_bit("R3", "if restored", if_flag, 1'b1);
    cycle();
    check_bit("R7", "only one pulse", nmi_req, 1'b0);
    // R3: resume outside ignored
    smm_resume = 1; cycle(); idle();
    // R8: edge in same cycle as enable write
    smm_enter = 1; cycle(); idle();
    nmi_in = 1; nmien_we = 1; nmien_wdata = 1; cycle(); idle();
    check_bit("R8", "same-cycle edge", nmi_req, 1'b1);
    cycle();
    check_bit("R6", "held high no repeat", nmi_req, 1'b0);
    nmi_in = 0; cycle();
    // R8: held event released by enable write
    nmien_we = 1; nmien_wdata = 0; cycle(); idle();
    nmi_in = 1; cycle(); nmi_in = 0; cycle();
    nmien_we = 1; nmien_wdata = 1; cycle(); idle();
    check_bit("R8", "release by write", nmi_req, 1'b1);
    smm_resume = 1; cycle(); idle();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      smm_enter   = ($urandom_range(99) < 6);
      smm_resume  = ($urandom_range(99) < 6);
      if_we       = ($urandom_range(99) < 12);
      if_wdata    = $urandom_range(1);
      nmien_we    = ($urandom_range(99) < 10);
      nmien_wdata = $urandom_range(1);
      if ($urandom_range(99) < 35) nmi_in = ~nmi_in;
      intr_in     = $urandom_range(1);
      cycle();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule